// File: doc/BRIEF.md
# FIFO Threshold Offset Programmer

This block keeps the two threshold offsets used by a synchronous FIFO's flag logic: one for the almost-empty flag and one for the almost-full flag. The FIFO's flag comparators read both offsets from the block's outputs. The FIFO storage, the pointers and the comparison itself are outside this block.

A strap input, `load_mode`, is sampled while master reset is held. It selects how the offsets are programmed and which defaults they take:

- **Serial programming:** one bit is loaded per enabled clock.
- **Parallel programming:** a whole word is loaded per write. Only this path can read the offsets back.

A four-state machine tracks the programming method and which register is loaded next. It has two serial states and two parallel states:

- `ST_SER_AE`: serial, almost-empty register is next. It moves to `ST_SER_AF` on the shift of bit 13, and is entered again from `ST_SER_AF` on that register's bit 13 (wrap).
- `ST_PAR_AE`: parallel, almost-empty register is next. It moves to `ST_PAR_AF` on any write or read.
- `ST_PAR_AF`: parallel, almost-full register is next. It returns to `ST_PAR_AE` on any write or read.

Reset enters `ST_SER_AE` when `load_mode` is HIGH and `ST_PAR_AE` when it is LOW. No transition ever crosses between the serial and the parallel pair.

Top module: `fifo_ofs_loader`

## Requirements
- R1: The level of `load_mode` at a clock edge with `mrst_n` LOW picks the method: 1 gives serial, 0 gives parallel. Changes of `load_mode` after reset have no effect until the next reset.
- R2: A reset with `load_mode`=1 sets both offsets to 0x3FF.
- R3: A reset with `load_mode`=0 sets both offsets to 0x07F.
- R4: In parallel mode, each clock with `wr_en`=1 loads `wdata` into one register, one cycle later. The first write after reset loads the almost-empty offset. Later writes alternate between the almost-almost-full and almost-empty offsets, starting with almost-full.
- R5: In parallel mode, a clock with `rd_en`=1 and `wr_en`=0 makes `rd_valid`=1 one cycle later. At the same time `rdata` shows the register that is next in sequence, and the read advances the same select toggle that writes use. In any cycle without a read, `rd_valid`=0 and `rdata` holds its value.
- R6: When `wr_en` and `rd_en` are both 1 in parallel mode, only the write takes place: `rd_valid` stays 0 and the toggle advances once.
- R7: In serial mode, each clock with `wr_en`=1 writes `sdin` into one bit of the current register, starting at bit 0 (LSB first). All 14 bits of almost-empty are loaded, then 14 bits of almost-full, and the sequence then wraps back to almost-empty bit 0. `wdata` is not used.
- R8: In serial mode, `rd_en` is ignored: `rd_valid` stays 0, `rdata` is unchanged and the bit sequence does not advance.
- R9: An offset changes only on a write or shift. With both `wr_en` and `rd_en` at 0, both offsets hold.
- R10: A new master reset restores the defaults and restarts the sequence at the almost-empty register, bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst_n | input | 1 | Master reset, active LOW, synchronous |
| load_mode | input | 1 | Method strap sampled during reset: 1 serial, 0 parallel |
| wr_en | input | 1 | Parallel word write, or serial bit shift |
| rd_en | input | 1 | Parallel readback request |
| sdin | input | 1 | Serial data bit |
| wdata | input | 14 | Parallel write word |
| ae_offset | output | 14 | Almost-empty offset to the flag logic |
| af_offset | output | 14 | Almost-full offset to the flag logic |
| rdata | output | 14 | Readback word |
| rd_valid | output | 1 | `rdata` updated by a read this cycle |

## Verification
Several properties are checked by the assertions on every cycle:

- the method stays fixed between resets;
- the bit counter stays in range;
- the parallel toggle alternates;
- the offsets stay unchanged when nothing is written;
- a serial-mode read never produces `rd_valid`.

Only the bench scenarios can show that the right value reaches the right register. These cover the reset defaults for each strap level, the write and read order, and the priority of a write over a read. They also check LSB-first serial assembly across both registers with the wrap, and that an interleaved serial read leaves the bit sequence where it was.

// File: rtl/fifo_ofs_pkg.sv
package fifo_ofs_pkg;
    typedef enum logic [1:0] {
        ST_PAR_AE = 2'b00,
        ST_PAR_AF = 2'b01,
        ST_SER_AE = 2'b10,
        ST_SER_AF = 2'b11
    } ldr_state_e;
endpackage

// File: rtl/fifo_ofs_seq.sv
module fifo_ofs_seq
    import fifo_ofs_pkg::*;
#(
    parameter int OFS_W = 14,
    localparam int IDX_W = $clog2(OFS_W)
) (
    input  logic             clk,
    input  logic             mrst_n,
    input  logic             load_mode,
    input  logic             wr_en,
    input  logic             rd_en,
    output logic             serial,
    output logic             sel_af,
    output logic             shift_en,
    output logic             par_wr,
    output logic             par_rd,
    output logic [IDX_W-1:0] bit_idx
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(OFS_W - 1);

    ldr_state_e state, state_nx;
    logic       last_bit;

    always_comb begin
        serial   = (state == ST_SER_AE) || (state == ST_SER_AF);
        sel_af   = (state == ST_PAR_AF) || (state == ST_SER_AF);
        shift_en = serial && wr_en;
        par_wr   = !serial && wr_en;
        par_rd   = !serial && rd_en && !wr_en;
        last_bit = (bit_idx == LAST_IDX);
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_SER_AE: if (shift_en && last_bit) state_nx = ST_SER_AF;
            ST_SER_AF: if (shift_en && last_bit) state_nx = ST_SER_AE;
            ST_PAR_AE: if (par_wr || par_rd)     state_nx = ST_PAR_AF;
            ST_PAR_AF: if (par_wr || par_rd)     state_nx = ST_PAR_AE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            state   <= load_mode ? ST_SER_AE : ST_PAR_AE;
            bit_idx <= '0;
        end else begin
            state <= state_nx;
            if (shift_en) bit_idx <= last_bit ? '0 : bit_idx + 1'b1;
        end
    end

    // R1
    mode_hold_chk: assert property (@(posedge clk) disable iff (!mrst_n)
        1'b1 |=> serial == $past(serial));

    // R7
    idx_range_chk: assert property (@(posedge clk) disable iff (!mrst_n)
        bit_idx <= LAST_IDX);

    // R4
    par_toggle_chk: assert property (@(posedge clk) disable iff (!mrst_n)
        (par_wr || par_rd) |=> sel_af != $past(sel_af));
endmodule

// File: rtl/fifo_ofs_regs.sv
module fifo_ofs_regs #(
    parameter int OFS_W   = 14,
    parameter int SER_DEF = 1023,
    parameter int PAR_DEF = 127,
    localparam int IDX_W  = $clog2(OFS_W)
) (
    input  logic             clk,
    input  logic             mrst_n,
    input  logic             load_mode,
    input  logic             shift_en,
    input  logic             par_wr,
    input  logic             sel_af,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             sdin,
    input  logic [OFS_W-1:0] wdata,
    output logic [OFS_W-1:0] ae_q,
    output logic [OFS_W-1:0] af_q
);
    localparam logic [OFS_W-1:0] SER_VAL = OFS_W'(SER_DEF);
    localparam logic [OFS_W-1:0] PAR_VAL = OFS_W'(PAR_DEF);

    logic [OFS_W-1:0] ofs_q [2];

    for (genvar g = 0; g < 2; g++) begin : g_ofs
        always_ff @(posedge clk) begin
            if (!mrst_n) begin
                ofs_q[g] <= load_mode ? SER_VAL : PAR_VAL;
            end else if (sel_af == g[0]) begin
                if (par_wr)        ofs_q[g]          <= wdata;
                else if (shift_en) ofs_q[g][bit_idx] <= sdin;
            end
        end
    end

    assign ae_q = ofs_q[0];
    assign af_q = ofs_q[1];

    // R9
    ofs_hold_chk: assert property (@(posedge clk) disable iff (!mrst_n)
        (!shift_en && !par_wr) |=> ($stable(ae_q) && $stable(af_q)));
endmodule

// File: rtl/fifo_ofs_rdback.sv
module fifo_ofs_rdback #(
    parameter int OFS_W = 14
) (
    input  logic             clk,
    input  logic             mrst_n,
    input  logic             par_rd,
    input  logic             sel_af,
    input  logic [OFS_W-1:0] ae_q,
    input  logic [OFS_W-1:0] af_q,
    output logic [OFS_W-1:0] rdata,
    output logic             rd_valid
);
    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            rdata    <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= par_rd;
            if (par_rd) rdata <= sel_af ? af_q : ae_q;
        end
    end

    // R5
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!mrst_n)
        !par_rd |=> $stable(rdata));
endmodule

// File: rtl/fifo_ofs_loader.sv
module fifo_ofs_loader #(
    parameter int OFS_W   = 14,
    parameter int SER_DEF = 1023,
    parameter int PAR_DEF = 127
) (
    input  logic             clk,
    input  logic             mrst_n,
    input  logic             load_mode,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic             sdin,
    input  logic [OFS_W-1:0] wdata,
    output logic [OFS_W-1:0] ae_offset,
    output logic [OFS_W-1:0] af_offset,
    output logic [OFS_W-1:0] rdata,
    output logic             rd_valid
);
    localparam int IDX_W = $clog2(OFS_W);

    logic             serial, sel_af, shift_en, par_wr, par_rd;
    logic [IDX_W-1:0] bit_idx;

    fifo_ofs_seq #(.OFS_W(OFS_W)) i_seq (
        .clk(clk), .mrst_n(mrst_n), .load_mode(load_mode),
        .wr_en(wr_en), .rd_en(rd_en),
        .serial(serial), .sel_af(sel_af), .shift_en(shift_en),
        .par_wr(par_wr), .par_rd(par_rd), .bit_idx(bit_idx)
    );

    fifo_ofs_regs #(.OFS_W(OFS_W), .SER_DEF(SER_DEF), .PAR_DEF(PAR_DEF)) i_regs (
        .clk(clk), .mrst_n(mrst_n), .load_mode(load_mode),
        .shift_en(shift_en), .par_wr(par_wr), .sel_af(sel_af),
        .bit_idx(bit_idx), .sdin(sdin), .wdata(wdata),
        .ae_q(ae_offset), .af_q(af_offset)
    );

    fifo_ofs_rdback #(.OFS_W(OFS_W)) i_rdback (
        .clk(clk), .mrst_n(mrst_n), .par_rd(par_rd), .sel_af(sel_af),
        .ae_q(ae_offset), .af_q(af_offset),
        .rdata(rdata), .rd_valid(rd_valid)
    );

    // R8
    ser_no_read_chk: assert property (@(posedge clk) disable iff (!mrst_n)
        serial |=> !rd_valid);

    // R6
    wr_wins_chk: assert property (@(posedge clk) disable iff (!mrst_n)
        (wr_en && rd_en) |=> !rd_valid);
endmodule

// File: tb/test_fifo_ofs_loader.sv
module test_fifo_ofs_loader;
    localparam int CLK_PER = 10;
    localparam int W = 14;
    localparam int NV = 10;

    logic         clk = 1'b0;
    logic         mrst_n, load_mode, wr_en, rd_en, sdin;
    logic [W-1:0] wdata, ae_offset, af_offset, rdata;
    logic         rd_valid;
    int           checks = 0, errors = 0;
    bit           done = 0;

    always #(CLK_PER/2) clk = ~clk;

    fifo_ofs_loader i_fifo_ofs_loader (
        .clk(clk), .mrst_n(mrst_n), .load_mode(load_mode),
        .wr_en(wr_en), .rd_en(rd_en), .sdin(sdin), .wdata(wdata),
        .ae_offset(ae_offset), .af_offset(af_offset),
        .rdata(rdata), .rd_valid(rd_valid)
    );

    // {wr, rd, wdata, exp_ae, exp_af, exp_valid, exp_rdata} ; parallel mode, R4/R5/R6
    localparam logic [58:0] VEC [NV] = '{
        {1'b1, 1'b0, 14'h0010, 14'h0010, 14'h007F, 1'b0, 14'h0000},
        {1'b1, 1'b0, 14'h0200, 14'h0010, 14'h0200, 1'b0, 14'h0000},
        {1'b0, 1'b1, 14'h0000, 14'h0010, 14'h0200, 1'b1, 14'h0010},
        {1'b0, 1'b1, 14'h0000, 14'h0010, 14'h0200, 1'b1, 14'h0200},
        {1'b1, 1'b1, 14'h0033, 14'h0033, 14'h0200, 1'b0, 14'h0200},
        {1'b0, 1'b0, 14'h1111, 14'h0033, 14'h0200, 1'b0, 14'h0200},
        {1'b0, 1'b1, 14'h0000, 14'h0033, 14'h0200, 1'b1, 14'h0200},
        {1'b1, 1'b0, 14'h3FFF, 14'h3FFF, 14'h0200, 1'b0, 14'h0200},
        {1'b1, 1'b0, 14'h0000, 14'h3FFF, 14'h0000, 1'b0, 14'h0200},
        {1'b0, 1'b1, 14'h0000, 14'h3FFF, 14'h0000, 1'b1, 14'h3FFF}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic mode);
        @(negedge clk);
        mrst_n = 1'b0; load_mode = mode; wr_en = 1'b0; rd_en = 1'b0;
        tick();
        tick();
        @(negedge clk);
        mrst_n = 1'b1;
    endtask

    task automatic shift_bits(input logic [W-1:0] val, input int from, input int upto);
        for (int i = from; i < upto; i++) begin
            @(negedge clk);
            wr_en = 1'b1; rd_en = 1'b0; sdin = val[i]; wdata = 14'h2AAA;
            tick();
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        mrst_n = 1'b0; load_mode = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        sdin = 1'b0; wdata = '0;

        // R3 parallel defaults
        do_reset(1'b0);
        check("R3 ae default", ae_offset, 14'h007F);
        check("R3 af default", af_offset, 14'h007F);
        check("R5 rd_valid reset", rd_valid, 0);
        load_mode = 1'b1;  // R1: strap change after reset ignored

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            wr_en = VEC[v][58]; rd_en = VEC[v][57]; wdata = VEC[v][56:43];
            tick();
            check($sformatf("R4 ae vec%0d", v), ae_offset, VEC[v][42:29]);
            check($sformatf("R4 af vec%0d", v), af_offset, VEC[v][28:15]);
            check($sformatf("R5/R6 valid vec%0d", v), rd_valid, VEC[v][14]);
            check($sformatf("R5 rdata vec%0d", v), rdata, VEC[v][13:0]);
        end
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        tick();
        check("R1 still parallel", rd_valid, 0);

        // R2 serial defaults
        do_reset(1'b1);
        check("R2 ae default", ae_offset, 14'h03FF);
        check("R2 af default", af_offset, 14'h03FF);
        load_mode = 1'b0;  // R1: ignored after reset

        // R7 LSB-first with interleaved read (R8)
        shift_bits(14'h1234, 0, 5);
        @(negedge clk);
        rd_en = 1'b1;
        tick();
        check("R8 serial read no valid", rd_valid, 0);
        check("R8 serial rdata held", rdata, 0);
        @(negedge clk);
        rd_en = 1'b0;
        shift_bits(14'h1234, 5, W);
        check("R7 ae serial", ae_offset, 14'h1234);
        check("R7 af untouched", af_offset, 14'h03FF);
        shift_bits(14'h2ABC, 0, W);
        check("R7 af serial", af_offset, 14'h2ABC);
        check("R7 ae kept", ae_offset, 14'h1234);
        tick();
        check("R9 idle hold", af_offset, 14'h2ABC);
        shift_bits(14'h0005, 0, W);
        check("R7 wrap to ae", ae_offset, 14'h0005);
        check("R7 wrap af kept", af_offset, 14'h2ABC);

        // R10 re-reset restores defaults and select
        shift_bits(14'h0000, 0, 3);
        do_reset(1'b0);
        check("R10 ae default", ae_offset, 14'h007F);
        check("R10 af default", af_offset, 14'h007F);
        @(negedge clk);
        wr_en = 1'b1; wdata = 14'h0ABC;
        tick();
        check("R10 first write to ae", ae_offset, 14'h0ABC);
        check("R10 af untouched", af_offset, 14'h007F);
        @(negedge clk);
        wr_en = 1'b0;

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule